// File: doc/BRIEF.md
# Format-Aware Pixel Output FIFO

This block is a 64-byte first-in first-out buffer between a pixel compositor (upstream) and an output timing stage (downstream), all on one clock. The compositor pushes bytes through a valid/ready handshake. The timing stage pulls one byte per active-video cycle with `pop`. The point at which the buffer reports itself full is not its raw depth. It is a lower level chosen by the selected output pixel format, so that the bytes of pixels the compositor already has in flight still fit after `in_ready` falls.

Software-visible control bits select these behaviours:
- an enable;
- an explicit clear;
- an automatic clear on every frame start;
- a hold that blocks popping until the first horizontal active start after enable;
- an underflow trigger that latches a sticky flag when a pop finds the buffer empty.

Full, empty, occupancy and underflow are reported as status outputs.

Top module: `pix_out_fifo`

## Requirements
- R1: With `en` high, a byte is stored when `in_valid` and `in_ready` are both high, and bytes leave in arrival order. `level` reports occupancy, which never exceeds 64.
- R2: With `fmt` = 0 or 1 (16-bit formats), the threshold is 52 bytes: `in_ready` is low and `full` is high when `level` >= 52.
- R3: With `fmt` = 2 (18-bit format), the threshold is 50 bytes.
- R4: With any other `fmt` value (3 to 7, 24-bit formats and default), the threshold is 46 bytes. In every format, `in_ready` = `en` and (`level` < threshold), and `full` = (`level` >= threshold).
- R5: A cycle with `fifo_clr` high leaves `level` at 0 on the next cycle. It discards any push or pop offered in that cycle and clears the underflow flag.
- R6: A `frame_start` pulse empties the buffer in the same way when `clr_at_start` is high. When `clr_at_start` is low the pulse has no effect. Neither case touches the underflow flag.
- R7: With `wait_hstart` high, pops are ignored after enable until the first `hstart` pulse. A pop in the `hstart` cycle itself is accepted. Dropping `en` re-arms the hold.
- R8: A pop accepted by the gate while the buffer is empty and `uf_trig` is high sets `underflow` on the next cycle. The flag stays set until `fifo_clr`. With `uf_trig` low, the same pop sets nothing.
- R9: `out_valid` is high in the same cycle as an accepted pop of a non-empty buffer, and `out_data` then shows the oldest byte. In all other cycles, underflow included, `out_data` is 0.
- R10: With `en` low, `in_ready` is 0 and pops are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable |
| fifo_clr | input | 1 | Explicit clear |
| clr_at_start | input | 1 | Clear on each frame start |
| frame_start | input | 1 | Frame start pulse |
| wait_hstart | input | 1 | Hold pops until first horizontal active start |
| hstart | input | 1 | Horizontal active start pulse |
| uf_trig | input | 1 | Underflow detection enable |
| fmt | input | 3 | Output pixel format select |
| in_valid | input | 1 | Upstream byte valid |
| in_data | input | 8 | Upstream byte |
| in_ready | output | 1 | Buffer accepts a byte |
| pop | input | 1 | Active-video byte request |
| out_valid | output | 1 | Byte delivered this cycle |
| out_data | output | 8 | Delivered byte, 0 when none |
| level | output | 7 | Occupancy in bytes |
| full | output | 1 | Occupancy at or above threshold |
| empty | output | 1 | Occupancy is zero |
| underflow | output | 1 | Sticky underflow flag |

## Verification
The assertions check the following on every cycle:
- the occupancy bound;
- that `in_ready` never stands above the format threshold;
- that a clear leaves the buffer empty;
- the stickiness of the underflow flag;
- the zero output during underflow;
- the silence of a closed hstart gate and of a disabled block.

Only the bench's scenarios can show the following:
- that bytes arrive in order;
- the exact stall level for each format;
- that a frame start without `clr_at_start` keeps the contents;
- the release of the hold in exactly the `hstart` cycle.

The bench shows these by comparing against a queue model on every clock.

// File: rtl/pofifo_pkg.sv
package pofifo_pkg;

  // Threshold in bytes at which the buffer reports full.
  // 0,1: 16-bit formats (2 bytes per in-flight pixel)
  // 2  : 18-bit format (fixed slack)
  // else: 24-bit formats and default (3 bytes per in-flight pixel)
  function automatic int unsigned full_threshold(input logic [2:0] fmt_sel,
                                                 input int unsigned depth,
                                                 input int unsigned lat_pix,
                                                 input int unsigned slack18);
    int unsigned thr;
    case (fmt_sel)
      3'd0, 3'd1: thr = depth - 2 * lat_pix;
      3'd2:       thr = depth - slack18;
      default:    thr = depth - 3 * lat_pix;
    endcase
    return thr;
  endfunction

endpackage

// File: rtl/pofifo_store.sv
module pofifo_store #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_evt,
  input  logic          push_evt,
  input  logic          pop_evt,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] head,
  output logic [LW-1:0] occ
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (push_evt && !clear_evt) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else if (clear_evt) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (push_evt) wr_ptr <= wr_ptr + 1'b1;
      if (pop_evt)  rd_ptr <= rd_ptr + 1'b1;
      case ({push_evt, pop_evt})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

  assign head = mem[rd_ptr];

  // R1: occupancy never passes capacity
  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= LW'(DEPTH));

  // R5: a clear leaves the store empty
  p_clear_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clear_evt |=> occ == '0);

endmodule

// File: rtl/pofifo_gate.sv
module pofifo_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic wait_hstart,
  input  logic hstart,
  output logic gate_open
);
  logic released;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        released <= 1'b0;
    else if (!en)      released <= 1'b0;
    else if (hstart)   released <= 1'b1;
  end

  assign gate_open = released || !wait_hstart || hstart;

  // R7: with the hold requested, dropping enable closes the gate
  p_rearm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && wait_hstart) |=> (!hstart && wait_hstart) |-> !gate_open);

endmodule

// File: rtl/pofifo_flags.sv
module pofifo_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_cmd,
  input  logic uf_evt,
  output logic uf_flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       uf_flag <= 1'b0;
    else if (clr_cmd) uf_flag <= 1'b0;
    else if (uf_evt)  uf_flag <= 1'b1;
  end

  // R8: flag is sticky until an explicit clear
  p_uf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (uf_flag && !clr_cmd) |=> uf_flag);

endmodule

// File: rtl/pix_out_fifo.sv
module pix_out_fifo #(
  parameter int unsigned DEPTH   = 64,
  parameter int unsigned DW      = 8,
  parameter int unsigned LAT_PIX = 6,
  parameter int unsigned SLACK18 = 14,
  localparam int unsigned LW     = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          fifo_clr,
  input  logic          clr_at_start,
  input  logic          frame_start,
  input  logic          wait_hstart,
  input  logic          hstart,
  input  logic          uf_trig,
  input  logic [2:0]    fmt,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  input  logic          pop,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty,
  output logic          underflow
);
  import pofifo_pkg::*;

  logic [LW-1:0] thr;
  logic          clear_evt, gate_open, pop_req, push_evt, pop_evt, uf_evt;
  logic [DW-1:0] head;

  assign thr       = LW'(full_threshold(fmt, DEPTH, LAT_PIX, SLACK18));
  assign clear_evt = fifo_clr || (clr_at_start && frame_start);
  assign pop_req   = pop && en && gate_open && !clear_evt;
  assign pop_evt   = pop_req && !empty;
  assign uf_evt    = pop_req && empty && uf_trig;
  assign full      = level >= thr;
  assign empty     = level == '0;
  assign in_ready  = en && !full;
  assign push_evt  = in_valid && in_ready && !clear_evt;
  assign out_valid = pop_evt;
  assign out_data  = pop_evt ? head : '0;

  pofifo_store #(.DEPTH(DEPTH), .DW(DW)) store_i (
    .clk(clk), .rst_n(rst_n), .clear_evt(clear_evt), .push_evt(push_evt),
    .pop_evt(pop_evt), .wdata(in_data), .head(head), .occ(level)
  );

  pofifo_gate gate_i (
    .clk(clk), .rst_n(rst_n), .en(en), .wait_hstart(wait_hstart),
    .hstart(hstart), .gate_open(gate_open)
  );

  pofifo_flags flags_i (
    .clk(clk), .rst_n(rst_n), .clr_cmd(fifo_clr), .uf_evt(uf_evt),
    .uf_flag(underflow)
  );

  // R2, R3, R4: ready only below the format threshold
  p_ready_below_thr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> level < thr);

  // R9: underflow cycle drives zero and no valid
  p_uf_zero_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
    uf_evt |-> (out_data == '0 && !out_valid));

  // R7: closed gate delivers nothing
  p_gate_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_open |-> !out_valid);

  // R10: disabled block neither accepts nor delivers
  p_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!in_ready && !out_valid));

endmodule

// File: tb/pix_out_fifo_tb.sv
module pix_out_fifo_tb_top;
  localparam int TCLK = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 0, fifo_clr = 0, clr_at_start = 0, frame_start = 0;
  logic wait_hstart = 0, hstart = 0, uf_trig = 0, in_valid = 0, pop = 0;
  logic [2:0] fmt = 0;
  logic [7:0] in_data = 0;
  logic in_ready, out_valid, full, empty, underflow;
  logic [7:0] out_data;
  logic [6:0] level;

  int errors = 0, checks = 0;
  bit done = 0;
  string phase = "R1 reset";

  byte unsigned q[$];
  bit m_uf = 0, m_rel = 0;
  logic [7:0] seed = 8'h5a;

  always #(TCLK/2) clk = ~clk;

  pix_out_fifo dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .fifo_clr(fifo_clr),
    .clr_at_start(clr_at_start), .frame_start(frame_start),
    .wait_hstart(wait_hstart), .hstart(hstart), .uf_trig(uf_trig),
    .fmt(fmt), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .pop(pop), .out_valid(out_valid), .out_data(out_data), .level(level),
    .full(full), .empty(empty), .underflow(underflow)
  );

  task automatic chk(input string req, input string sig, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s [%s] %s: got %0d expected %0d", req, phase, sig, got, exp);
    end
  endtask

  // One clock: inputs already set; compare, advance model, wait for next negedge.
  task automatic tick();
    int thr, sz;
    bit clr, gate, preq, ev, er;
    string rq;
    #1;
    sz   = q.size();
    thr  = (fmt < 2) ? 52 : (fmt == 2) ? 50 : 46;
    rq   = (fmt < 2) ? "R2" : (fmt == 2) ? "R3" : "R4";
    clr  = fifo_clr || (clr_at_start && frame_start);
    gate = m_rel || !wait_hstart || hstart;
    preq = pop && en && gate && !clr;
    ev   = preq && sz > 0;
    er   = en && sz < thr;
    chk(rq, "in_ready", int'(in_ready), int'(er));
    chk(rq, "full", int'(full), int'(sz >= thr));
    chk("R1", "level", int'(level), sz);
    chk("R1", "empty", int'(empty), int'(sz == 0));
    chk("R9", "out_valid", int'(out_valid), int'(ev));
    chk("R9", "out_data", int'(out_data), ev ? int'(q[0]) : 0);
    chk("R8", "underflow", int'(underflow), int'(m_uf));
    if (clr) q.delete();
    else begin
      if (ev) void'(q.pop_front());
      if (in_valid && er) q.push_back(in_data);
    end
    if (fifo_clr) m_uf = 0;
    else if (preq && sz == 0 && uf_trig) m_uf = 1;
    if (!en) m_rel = 0; else if (hstart) m_rel = 1;
    @(negedge clk);
    in_data = in_data + 8'd1;
  endtask

  task automatic clear1();
    fifo_clr = 1; in_valid = 1; pop = 1; tick();
    fifo_clr = 0; in_valid = 0; pop = 0;
  endtask

  task automatic fill_drain(input logic [2:0] f, input string ph);
    phase = ph; fmt = f;
    in_valid = 1; repeat (60) tick();
    in_valid = 0; pop = 1; repeat (56) tick();
    pop = 0;
  endtask

  initial begin
    #(TCLK * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1", "reset level", int'(level), 0);
    chk("R1", "reset empty", int'(empty), 1);
    chk("R8", "reset underflow", int'(underflow), 0);
    rst_n = 1; @(negedge clk);

    // Reset control sequence: 0, clear with enable, 0
    phase = "R5 init"; fifo_clr = 1; en = 1; tick(); fifo_clr = 0;

    fill_drain(3'd0, "R2 fmt0");
    fill_drain(3'd1, "R2 fmt1");
    fill_drain(3'd2, "R3 fmt2");
    fill_drain(3'd3, "R4 fmt3");
    fill_drain(3'd6, "R4 fmt6");

    phase = "R1 mixed"; fmt = 0;
    for (int i = 0; i < 300; i++) begin
      seed = {seed[6:0], seed[7] ^ seed[5] ^ seed[4] ^ seed[3]};
      in_valid = seed[0] | seed[1];
      pop = seed[2] & (i > 20);
      tick();
    end
    in_valid = 0; pop = 0;

    phase = "R5 clear"; in_valid = 1; repeat (10) tick(); in_valid = 0;
    clear1(); repeat (2) tick();

    phase = "R8 no trig"; pop = 1; repeat (3) tick();
    phase = "R8 trig"; uf_trig = 1; repeat (3) tick(); pop = 0;
    in_valid = 1; repeat (4) tick(); in_valid = 0;
    phase = "R9 after uf"; pop = 1; repeat (6) tick(); pop = 0;
    phase = "R5 uf clear"; clear1(); repeat (2) tick(); uf_trig = 0;

    phase = "R6 no auto"; in_valid = 1; repeat (8) tick(); in_valid = 0;
    frame_start = 1; tick(); frame_start = 0; repeat (2) tick();
    phase = "R6 auto"; clr_at_start = 1; frame_start = 1; in_valid = 1; tick();
    frame_start = 0; in_valid = 0; repeat (2) tick(); clr_at_start = 0;

    phase = "R10 off"; en = 0; in_valid = 1; pop = 1; repeat (5) tick();
    in_valid = 0; pop = 0;
    phase = "R7 hold"; wait_hstart = 1; en = 1; in_valid = 1; repeat (6) tick();
    in_valid = 0; pop = 1; repeat (4) tick();
    hstart = 1; tick(); hstart = 0; repeat (3) tick();
    pop = 0; en = 0; tick(); en = 1;
    phase = "R7 rearm"; pop = 1; repeat (3) tick();
    hstart = 1; tick(); hstart = 0; repeat (5) tick(); pop = 0;
    wait_hstart = 0; repeat (2) tick();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule